// File: doc/BRIEF.md
# Shadowed Video Clock Divider Bank

This block holds fourteen programmable power-of-two clock dividers for a video output unit that has two pipelines, main and auxiliary. Each pipeline has seven dividers: VGA, picture, TV encoder, HDMI pixel-extension, HDMI, interface and layer. Every divider takes the one shared input clock and produces a single-cycle clock-enable pulse. The pulse is high once every 1, 2, 4 or 8 input cycles.

Software programs 3-bit ratio codes through a plain 32-bit register write port. The codes go into two control words, the source word and the ratio word. A code written there is only staged. The active dividers take all fourteen staged codes together, and only when the flag bit in the ratio word goes from 0 to 1. The intended sequence is as follows:

1. Clear the flag.
2. Read-modify-write any number of 3-bit fields.
3. Set the flag.

Each divider switches to its new ratio only at the end of the period it is in, so no shortened enable period appears.

Top module: `vclk_div_bank`

## Requirements
- R1: After reset both control words read 0, every active code is 0, and every `tick_o` bit is high on every cycle.
- R2: A write to byte offset 0x18 (source word) or 0x1C (ratio word) stores all 32 bits, and a read of that offset returns exactly the stored value. Writes to any other offset change nothing, and reads of any other offset return 0.
- R3: Divider `tick_o[k]` belongs to the main pipeline and `tick_o[7+k]` to the auxiliary one, with k = 0 VGA, 1 picture, 2 TV encoder, 3 HDMI pixel-extension, 4 HDMI, 5 interface, 6 layer. Each code field is 3 bits wide, and its least significant bit sits at the position below (main/aux).
  - In the source word: VGA 26/29 and picture 23/20.
  - In the ratio word: TV encoder 13/28, HDMI pixel-extension 22/25, HDMI 16/19, interface 6/9 and layer 0/3.
- R4: An active code of 0, 1, 3 or 7 makes the divider's `tick_o` bit a one-cycle pulse, repeating every 1, 2, 4 or 8 input cycles respectively.
- R5: Writing new codes while the flag (ratio word bit 31) stays at 0 leaves every divider output period unchanged.
- R6: When the flag goes from 0 to 1, all fourteen staged codes become active together, in the cycle after the write.
- R7: Codes written while the flag is already 1, with the flag kept at 1, stay staged and do not take effect until the next 0-to-1 transition.
- R8: A code outside {0,1,3,7} acts as the longest run of ones counted up from bit 0. For example, 5 acts as 1, while 2, 4 and 6 act as 0.
- R9: A divider takes a new ratio only at the end of its current period. Every interval between consecutive pulses therefore equals either the old ratio or the new ratio.
- R10: Writes to the ratio word never alter the source word, including its layer clock-source bits 8 down to 4.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Shared input clock |
| rst_ni | input | 1 | Asynchronous active-low reset, released synchronously |
| wr_en_i | input | 1 | Register write strobe |
| wr_addr_i | input | 8 | Byte offset of the write |
| wr_data_i | input | 32 | Write data |
| rd_addr_i | input | 8 | Byte offset of the read |
| rd_data_o | output | 32 | Read data for `rd_addr_i`, available in the same cycle |
| tick_o | output | 14 | One clock-enable pulse per divider, indexed as in R3 |

## Verification
The hardest case to reach from the ports is a ratio change that lands in the middle of a long divide period.

- The bench runs a divider at divide-by-8 and commits divide-by-2, and then does the reverse.
- In each case it records several consecutive pulse intervals right after the flag edge, so the switch falls at an arbitrary point in the count.
- Every interval recorded must be 8 or 2.

The other hard case is a flag that is held high:

- New codes are written with bit 31 kept set, and the bench confirms that the old periods remain.
- Only after the bench clears and sets the flag again does it expect the new periods.

// File: rtl/vclk_div_pkg.sv
package vclk_div_pkg;

  localparam int unsigned CODE_W    = 3;
  localparam int unsigned NUM_CH    = 7;
  localparam int unsigned NUM_DIV   = 2 * NUM_CH;
  localparam int unsigned DATA_W    = 32;
  localparam int unsigned ADDR_W    = 8;
  localparam int unsigned FLAG_BIT  = 31;
  localparam logic [ADDR_W-1:0] SEL_OFS   = 8'h18;
  localparam logic [ADDR_W-1:0] RATIO_OFS = 8'h1C;

  typedef enum logic {
    WORD_SEL   = 1'b0,
    WORD_RATIO = 1'b1
  } word_e;

  // Channel order inside one pipeline: vga, picture, tv encoder,
  // hdmi pixel-extension, hdmi, interface, layer.
  function automatic word_e field_word(int unsigned idx);
    int unsigned ch;
    ch = idx % NUM_CH;
    return (ch < 2) ? WORD_SEL : WORD_RATIO;
  endfunction

  function automatic int unsigned field_lsb(int unsigned idx);
    int unsigned ch;
    logic        aux;
    ch  = idx % NUM_CH;
    aux = (idx >= NUM_CH);
    case (ch)
      0:       return aux ? 29 : 26;
      1:       return aux ? 20 : 23;
      2:       return aux ? 28 : 13;
      3:       return aux ? 25 : 22;
      4:       return aux ? 19 : 16;
      5:       return aux ? 9  : 6;
      default: return aux ? 3  : 0;
    endcase
  endfunction

  // Keep the contiguous run of ones starting at bit 0.
  function automatic logic [CODE_W-1:0] legal_mask(logic [CODE_W-1:0] c);
    logic [CODE_W-1:0] m;
    logic              keep;
    m    = '0;
    keep = 1'b1;
    for (int b = 0; b < CODE_W; b++) begin
      keep = keep & c[b];
      m[b] = keep;
    end
    return m;
  endfunction

endpackage

// File: rtl/vclk_div_regs.sv
module vclk_div_regs
  import vclk_div_pkg::*;
#(
  parameter int unsigned P_ADDR_W = ADDR_W,
  parameter int unsigned P_DATA_W = DATA_W,
  parameter int unsigned P_CODE_W = CODE_W,
  parameter int unsigned P_NUM    = NUM_DIV,
  parameter int unsigned P_FLAG   = FLAG_BIT
) (
  input  logic                      clk_i,
  input  logic                      rst_ni,
  input  logic                      wr_en_i,
  input  logic [P_ADDR_W-1:0]       wr_addr_i,
  input  logic [P_DATA_W-1:0]       wr_data_i,
  input  logic [P_ADDR_W-1:0]       rd_addr_i,
  output logic [P_DATA_W-1:0]       rd_data_o,
  output logic [P_DATA_W-1:0]       sel_word_o,
  output logic                      flag_o,
  output logic [P_NUM*P_CODE_W-1:0] act_codes_o
);

  localparam int unsigned TOT_W = P_NUM * P_CODE_W;

  logic [P_DATA_W-1:0] sel_q, sel_d;
  logic [P_DATA_W-1:0] ratio_q, ratio_d;
  logic                flag_q;
  logic                upd_rise;
  logic [TOT_W-1:0]    staged;
  logic [TOT_W-1:0]    act_q, act_d;

  for (genvar g = 0; g < P_NUM; g++) begin : g_stage
    localparam int unsigned LSB = field_lsb(g);
    if (field_word(g) == WORD_SEL) begin : g_sel
      assign staged[g*P_CODE_W +: P_CODE_W] = legal_mask(sel_q[LSB +: P_CODE_W]);
    end else begin : g_ratio
      assign staged[g*P_CODE_W +: P_CODE_W] = legal_mask(ratio_q[LSB +: P_CODE_W]);
    end
  end

  assign upd_rise = ratio_q[P_FLAG] & ~flag_q;

  always_comb begin
    sel_d   = sel_q;
    ratio_d = ratio_q;
    if (wr_en_i && (wr_addr_i == SEL_OFS))   sel_d   = wr_data_i;
    if (wr_en_i && (wr_addr_i == RATIO_OFS)) ratio_d = wr_data_i;
    act_d = upd_rise ? staged : act_q;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      sel_q   <= '0;
      ratio_q <= '0;
      flag_q  <= 1'b0;
      act_q   <= '0;
    end else begin
      sel_q   <= sel_d;
      ratio_q <= ratio_d;
      flag_q  <= ratio_q[P_FLAG];
      act_q   <= act_d;
    end
  end

  always_comb begin
    rd_data_o = '0;
    if (rd_addr_i == SEL_OFS)        rd_data_o = sel_q;
    else if (rd_addr_i == RATIO_OFS) rd_data_o = ratio_q;
  end

  assign sel_word_o  = sel_q;
  assign flag_o      = ratio_q[P_FLAG];
  assign act_codes_o = act_q;

endmodule

// File: rtl/vclk_div_cell.sv
module vclk_div_cell #(
  parameter int unsigned P_CODE_W = vclk_div_pkg::CODE_W
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic [P_CODE_W-1:0] code_i,
  output logic [P_CODE_W-1:0] run_o,
  output logic                tick_o
);

  logic [P_CODE_W-1:0] cnt_q, cnt_d;
  logic [P_CODE_W-1:0] run_q, run_d;
  logic                wrap;

  assign wrap = (cnt_q == run_q);

  always_comb begin
    cnt_d = cnt_q + P_CODE_W'(1);
    run_d = run_q;
    if (wrap) begin
      cnt_d = '0;
      run_d = code_i;
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      cnt_q <= '0;
      run_q <= '0;
    end else begin
      cnt_q <= cnt_d;
      run_q <= run_d;
    end
  end

  assign tick_o = (cnt_q == '0);
  assign run_o  = run_q;

endmodule

// File: rtl/vclk_div_bank.sv
module vclk_div_bank
  import vclk_div_pkg::*;
#(
  parameter int unsigned P_ADDR_W = ADDR_W,
  parameter int unsigned P_DATA_W = DATA_W,
  parameter int unsigned P_CODE_W = CODE_W,
  parameter int unsigned P_NUM    = NUM_DIV
) (
  input  logic                clk_i,
  input  logic                rst_ni,
  input  logic                wr_en_i,
  input  logic [P_ADDR_W-1:0] wr_addr_i,
  input  logic [P_DATA_W-1:0] wr_data_i,
  input  logic [P_ADDR_W-1:0] rd_addr_i,
  output logic [P_DATA_W-1:0] rd_data_o,
  output logic [P_NUM-1:0]    tick_o
);

  logic [P_DATA_W-1:0]       sel_word;
  logic                      upd_flag;
  logic [P_NUM*P_CODE_W-1:0] act_codes;
  logic [P_NUM*P_CODE_W-1:0] run_codes;

  vclk_div_regs #(
    .P_ADDR_W (P_ADDR_W),
    .P_DATA_W (P_DATA_W),
    .P_CODE_W (P_CODE_W),
    .P_NUM    (P_NUM),
    .P_FLAG   (FLAG_BIT)
  ) regs_i (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .wr_en_i     (wr_en_i),
    .wr_addr_i   (wr_addr_i),
    .wr_data_i   (wr_data_i),
    .rd_addr_i   (rd_addr_i),
    .rd_data_o   (rd_data_o),
    .sel_word_o  (sel_word),
    .flag_o      (upd_flag),
    .act_codes_o (act_codes)
  );

  for (genvar g = 0; g < P_NUM; g++) begin : g_div
    vclk_div_cell #(.P_CODE_W(P_CODE_W)) div_i (
      .clk_i  (clk_i),
      .rst_ni (rst_ni),
      .code_i (act_codes[g*P_CODE_W +: P_CODE_W]),
      .run_o  (run_codes[g*P_CODE_W +: P_CODE_W]),
      .tick_o (tick_o[g])
    );
  end

endmodule

// File: rtl/vclk_div_bank_chk.sv
module vclk_div_bank_chk #(
  parameter int unsigned P_ADDR_W = vclk_div_pkg::ADDR_W,
  parameter int unsigned P_DATA_W = vclk_div_pkg::DATA_W,
  parameter int unsigned P_CODE_W = vclk_div_pkg::CODE_W,
  parameter int unsigned P_NUM    = vclk_div_pkg::NUM_DIV
) (
  input logic                      clk_i,
  input logic                      rst_ni,
  input logic                      wr_en_i,
  input logic [P_ADDR_W-1:0]       wr_addr_i,
  input logic [P_DATA_W-1:0]       sel_word_i,
  input logic                      flag_i,
  input logic [P_NUM*P_CODE_W-1:0] act_i,
  input logic [P_NUM*P_CODE_W-1:0] run_i,
  input logic [P_NUM-1:0]          tick_i
);

  logic flag_d_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) flag_d_q <= 1'b0;
    else         flag_d_q <= flag_i;
  end

  // R10: only a write to the source offset may change the source word.
  p_sel_kept_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!wr_en_i || (wr_addr_i != vclk_div_pkg::SEL_OFS)) |=> $stable(sel_word_i));

  // R5 / R6: active codes move only after a 0-to-1 flag transition.
  p_load_on_rise_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(flag_i && !flag_d_q) |=> $stable(act_i));

  // R7: a flag held high keeps the active codes frozen.
  p_hold_high_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (flag_i && flag_d_q) |=> $stable(act_i));

  for (genvar g = 0; g < P_NUM; g++) begin : g_chk
    logic [P_CODE_W-1:0] a, a_inc;
    assign a     = act_i[g*P_CODE_W +: P_CODE_W];
    assign a_inc = a + P_CODE_W'(1);

    // R8: active codes are always contiguous masks from bit 0.
    p_legal_mask_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ((a & a_inc) == '0));

    // R4: a ratio above one never yields two pulses in a row.
    p_pulse_gap_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (tick_i[g] && (run_i[g*P_CODE_W +: P_CODE_W] != '0)) |=> !tick_i[g]);

    // R9: the running ratio changes only where a new period starts.
    p_switch_at_wrap_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !$stable(run_i[g*P_CODE_W +: P_CODE_W]) |-> tick_i[g]);
  end

endmodule

bind vclk_div_bank vclk_div_bank_chk #(
  .P_ADDR_W (P_ADDR_W),
  .P_DATA_W (P_DATA_W),
  .P_CODE_W (P_CODE_W),
  .P_NUM    (P_NUM)
) chk_i (
  .clk_i      (clk_i),
  .rst_ni     (rst_ni),
  .wr_en_i    (wr_en_i),
  .wr_addr_i  (wr_addr_i),
  .sel_word_i (sel_word),
  .flag_i     (upd_flag),
  .act_i      (act_codes),
  .run_i      (run_codes),
  .tick_i     (tick_o)
);

// File: tb/vclk_div_bank_tb_top.sv
`timescale 1ns/1ps
module vclk_div_bank_tb_top;

  localparam int NDIV   = 14;
  localparam logic [7:0] A_SEL   = 8'h18;
  localparam logic [7:0] A_RATIO = 8'h1C;
  localparam logic [31:0] FLAG   = 32'h8000_0000;

  logic        clk = 1'b0;
  logic        rst_ni;
  logic        wr_en_i;
  logic [7:0]  wr_addr_i;
  logic [31:0] wr_data_i;
  logic [7:0]  rd_addr_i;
  logic [31:0] rd_data_o;
  logic [13:0] tick_o;

  int n_chk  = 0;
  int n_fail = 0;
  logic [31:0] sel_w, ratio_w;

  always #10 clk = ~clk;

  vclk_div_bank dut_i (
    .clk_i     (clk),
    .rst_ni    (rst_ni),
    .wr_en_i   (wr_en_i),
    .wr_addr_i (wr_addr_i),
    .wr_data_i (wr_data_i),
    .rd_addr_i (rd_addr_i),
    .rd_data_o (rd_data_o),
    .tick_o    (tick_o)
  );

  function automatic int pos_of(int idx);
    case (idx)
      0: return 26;  1: return 23;  2: return 13;  3: return 22;
      4: return 16;  5: return 6;   6: return 0;   7: return 29;
      8: return 20;  9: return 28; 10: return 25; 11: return 19;
      12: return 9;  default: return 3;
    endcase
  endfunction

  function automatic bit in_sel(int idx);
    return (idx == 0) || (idx == 1) || (idx == 7) || (idx == 8);
  endfunction

  function automatic int exp_ratio(logic [2:0] c);
    if (c == 3'd7)       return 8;
    if (c[1:0] == 2'b11) return 4;
    if (c[0])            return 2;
    return 1;
  endfunction

  task automatic check(string req, string what, longint act, longint exp);
    n_chk++;
    if (act != exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
    end
  endtask

  task automatic wr(logic [7:0] a, logic [31:0] d);
    @(negedge clk);
    wr_en_i = 1'b1; wr_addr_i = a; wr_data_i = d;
    @(negedge clk);
    wr_en_i = 1'b0;
  endtask

  task automatic rd(logic [7:0] a, output logic [31:0] d);
    @(negedge clk);
    rd_addr_i = a;
    #1 d = rd_data_o;
  endtask

  task automatic measure(int idx, output int n);
    n = 0;
    for (int k = 0; k < 20; k++) begin
      @(negedge clk);
      if (tick_o[idx]) break;
    end
    for (int k = 0; k < 32; k++) begin
      @(negedge clk);
      n++;
      if (tick_o[idx]) break;
    end
  endtask

  task automatic set_code(int idx, logic [2:0] c);
    if (in_sel(idx)) sel_w[pos_of(idx) +: 3] = c;
    else             ratio_w[pos_of(idx) +: 3] = c;
  endtask

  task automatic commit();
    wr(A_SEL, sel_w);
    wr(A_RATIO, ratio_w & ~FLAG);
    wr(A_RATIO, ratio_w | FLAG);
  endtask

  task automatic settle();
    repeat (20) @(negedge clk);
  endtask

  task automatic t_reset();
    logic [31:0] d;
    int n;
    rd(A_SEL, d);   check("R1", "source word after reset", d, 0);
    rd(A_RATIO, d); check("R1", "ratio word after reset", d, 0);
    for (int i = 0; i < NDIV; i++) begin
      measure(i, n); check("R1", $sformatf("interval div %0d", i), n, 1);
    end
  endtask

  task automatic t_regmap();
    logic [31:0] d;
    sel_w = 32'h0000_01F0;
    wr(A_SEL, sel_w);
    wr(A_RATIO, 32'h1234_5678 & ~FLAG);
    rd(A_RATIO, d); check("R2", "ratio readback", d, 32'h1234_5678 & ~FLAG);
    wr(8'h20, 32'hFFFF_FFFF);
    rd(8'h20, d);   check("R2", "unmapped read", d, 0);
    rd(A_SEL, d);   check("R10", "source word kept", d, sel_w);
    ratio_w = 32'h0;
    wr(A_RATIO, ratio_w);
  endtask

  task automatic t_program();
    logic [31:0] d;
    logic [2:0] cs [4] = '{3'd0, 3'd1, 3'd3, 3'd7};
    int n;
    for (int i = 0; i < NDIV; i++) set_code(i, cs[(i + 1) % 4]);
    wr(A_SEL, sel_w);
    wr(A_RATIO, ratio_w);
    settle();
    measure(3, n);  check("R5", "no flag edge, div 3", n, 1);
    measure(12, n); check("R5", "no flag edge, div 12", n, 1);
    commit();
    settle();
    for (int i = 0; i < NDIV; i++) begin
      measure(i, n);
      check("R4", $sformatf("R3 R6 interval div %0d", i), n, exp_ratio(cs[(i + 1) % 4]));
    end
    rd(A_SEL, d); check("R10", "select bits after ratio writes", d[8:4], 5'h1F);
    rd(A_RATIO, d); check("R2", "ratio readback with flag", d, ratio_w | FLAG);
  endtask

  task automatic t_hold_high();
    int n;
    int old0, old6;
    old0 = exp_ratio(sel_w[pos_of(0) +: 3]);
    old6 = exp_ratio(ratio_w[pos_of(6) +: 3]);
    set_code(0, 3'd3);
    set_code(6, 3'd7);
    wr(A_SEL, sel_w);
    wr(A_RATIO, ratio_w | FLAG);
    settle();
    measure(0, n); check("R7", "held flag, div 0", n, old0);
    measure(6, n); check("R7", "held flag, div 6", n, old6);
    commit();
    settle();
    measure(0, n); check("R7", "after re-edge, div 0", n, 4);
    measure(6, n); check("R7", "after re-edge, div 6", n, 8);
  endtask

  task automatic t_illegal();
    logic [2:0] cs [4] = '{3'd5, 3'd2, 3'd6, 3'd4};
    int n;
    for (int i = 0; i < 4; i++) set_code(9 + i, cs[i]);
    commit();
    settle();
    for (int i = 0; i < 4; i++) begin
      measure(9 + i, n);
      check("R8", $sformatf("code %0d interval", cs[i]), n, exp_ratio(cs[i]));
    end
  endtask

  task automatic t_switch(logic [2:0] from_c, logic [2:0] to_c);
    int n;
    int a, b;
    set_code(2, from_c);
    commit();
    settle();
    a = exp_ratio(from_c);
    b = exp_ratio(to_c);
    set_code(2, to_c);
    commit();
    for (int k = 0; k < 4; k++) begin
      measure(2, n);
      check("R9", $sformatf("interval %0d during switch", k), (n == a || n == b) ? n : -n, n);
    end
    settle();
    measure(2, n); check("R9", "final interval", n, b);
  endtask

  initial begin
    #(20 * 200000);
    n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

  initial begin
    rst_ni = 1'b0; wr_en_i = 1'b0; wr_addr_i = '0; wr_data_i = '0; rd_addr_i = '0;
    sel_w = '0; ratio_w = '0;
    repeat (3) @(negedge clk);
    rst_ni = 1'b1;
    t_reset();
    t_regmap();
    t_program();
    t_hold_high();
    t_illegal();
    t_switch(3'd7, 3'd1);
    t_switch(3'd1, 3'd7);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end

endmodule